// File: doc/BRIEF.md
# Complement-Recompute Adder Checker

This block wraps a single combinational binary adder with a time-redundant error detector. A binary adder is self-dual: if every input line, carry-in included, is inverted, every output line, carry-out included, comes out inverted. The block uses this property. On an accepted start it adds the true operands and carry-in and holds that result. In the next cycle it feeds the same adder the inverted operands and the inverted carry-in. It then raises the error output unless each bit of the second result is the opposite of the matching bit of the first.

The reported sum and carry-out are those of the first pass. A line stuck at either level on the adder's inputs or outputs breaks the complement relation between the two passes, so such a fault is always flagged. A test hook can pin any one of the adder's 3·WIDTH+2 lines to a chosen level, which lets the detection be exercised on purpose. Parameters set the adder width, the adder structure (ripple chain or native operator), and whether the fault hook is built.

Top module: `alt_logic_adder_chk`

## Requirements
- R1: A start seen while the block is idle (start high in cycle 0) makes done_o high for exactly one cycle, in cycle 2.
- R2: With no fault active, {cout_o, sum_o} equals a_i + b_i + cin_i as sampled in the start cycle, and err_o is 0.
- R3: The second pass applies the bitwise inverse of a_i, b_i and cin_i to the same adder. err_o is 0 only if every one of the WIDTH+1 second-pass output bits is the inverse of its first-pass counterpart.
- R4: Fault sites 2·WIDTH+1 to 3·WIDTH+1 pin adder output lines (sum bit j is site 2·WIDTH+1+j, and carry-out is site 3·WIDTH+1). With such a site active during both passes, err_o is 1 and the reported result is the true sum with that bit replaced by flt_val_i.
- R5: Fault sites 0 to 2·WIDTH pin adder input lines (operand A bit i is site i, operand B bit i is site WIDTH+i, and carry-in is site 2·WIDTH). With such a site active, err_o is 1 and the reported result is the sum of the pinned inputs.
- R6: A fault site index of 3·WIDTH+2 or above, or flt_en_i low, has no effect on sum_o, cout_o or err_o.
- R7: A start in cycle 1, while the second pass is running, is ignored. No extra done_o pulse follows, and the result is that of the first start.
- R8: sum_o, cout_o and err_o change only in the cycle in which done_o is high, and hold their values otherwise.
- R9: While rst_n is low, sum_o, cout_o, done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a checked addition (taken only when idle) |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| flt_en_i | input | 1 | Enables the fault hook |
| flt_site_i | input | SITE_W | Index of the adder line to pin |
| flt_val_i | input | 1 | Level that the selected line is pinned to |
| sum_o | output | WIDTH | First-pass sum |
| cout_o | output | 1 | First-pass carry-out |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Complement check failed |

## Verification
An accepted start in cycle 0 gives a done_o pulse in cycle 2. The result, carry and error outputs are updated in that same cycle and stay fixed until the next pulse. The bench drives inputs and samples outputs on falling clock edges. It checks done, sum, carry and error exactly two falling edges after the start, then checks one edge later that done has dropped and the outputs are unchanged. The fault inputs are kept steady across both passes, so each expected error is defined for both passes.

// File: rtl/altl_pkg.sv
package altl_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_DUAL = 1'b1
   } altl_phase_e;

   localparam int unsigned ADD_RIPPLE = 0;
   localparam int unsigned ADD_NATIVE = 1;

   function automatic int unsigned line_count(input int unsigned w);
      return 3 * w + 2;
   endfunction

endpackage

// File: rtl/altl_adder_core.sv
module altl_adder_core #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned KIND  = altl_pkg::ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);

   initial begin
      assert (KIND <= altl_pkg::ADD_NATIVE)
         else $error("altl_adder_core: unknown adder kind %0d", KIND);
   end

   generate
      if (KIND == altl_pkg::ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = opa[i] ^ opb[i] ^ cy[i];
            assign cy[i+1] = (opa[i] & opb[i]) | (opa[i] & cy[i]) | (opb[i] & cy[i]);
         end
         assign co = cy[WIDTH];
      end else begin : g_native
         logic [WIDTH:0] total;
         assign total     = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci};
         assign {co, sum} = total;
      end
   endgenerate

endmodule

// File: rtl/altl_line_fault.sv
module altl_line_fault #(
   parameter int unsigned N     = 8,
   parameter int unsigned BASE  = 0,
   parameter int unsigned SELW  = 5,
   parameter bit          HOOK  = 1'b1
) (
   input  logic [N-1:0]    line_i,
   input  logic            fault_en,
   input  logic [SELW-1:0] fault_sel,
   input  logic            fault_val,
   output logic [N-1:0]    line_o
);

   initial begin
      assert (BASE + N <= (1 << SELW))
         else $error("altl_line_fault: site index does not fit select width");
   end

   generate
      if (HOOK) begin : g_hook
         for (genvar i = 0; i < N; i++) begin : g_line
            localparam logic [SELW-1:0] SITE_ID = SELW'(BASE + i);
            assign line_o[i] = (fault_en && (fault_sel == SITE_ID)) ? fault_val : line_i[i];
         end
      end else begin : g_pass
         logic unused_hook;
         assign unused_hook = ^{fault_en, fault_sel, fault_val};
         assign line_o      = line_i;
      end
   endgenerate

endmodule

// File: rtl/altl_dual_cmp.sv
module altl_dual_cmp #(
   parameter int unsigned N = 9
) (
   input  logic [N-1:0] first_i,
   input  logic [N-1:0] second_i,
   output logic         bad_o
);

   logic [N-1:0] same_bit;

   generate
      for (genvar i = 0; i < N; i++) begin : g_xnor
         assign same_bit[i] = ~(first_i[i] ^ second_i[i]);
      end
   endgenerate

   assign bad_o = |same_bit;

endmodule

// File: rtl/altl_dual_ctrl.sv
module altl_dual_ctrl #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   input  logic [WIDTH-1:0] res_sum,
   input  logic             res_co,
   output logic [WIDTH-1:0] drv_a,
   output logic [WIDTH-1:0] drv_b,
   output logic             drv_ci,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             done_o,
   output logic             err_o,
   output logic             busy_o
);

   import altl_pkg::*;

   localparam int unsigned RW = WIDTH + 1;

   altl_phase_e      phase;
   logic [WIDTH-1:0] inv_a;
   logic [WIDTH-1:0] inv_b;
   logic             inv_ci;
   logic [RW-1:0]    hold_res;
   logic             cmp_bad;

   assign busy_o = (phase == PH_DUAL);
   assign drv_a  = busy_o ? inv_a  : a_i;
   assign drv_b  = busy_o ? inv_b  : b_i;
   assign drv_ci = busy_o ? inv_ci : cin_i;

   altl_dual_cmp #(.N(RW)) u_cmp (
      .first_i  (hold_res),
      .second_i ({res_co, res_sum}),
      .bad_o    (cmp_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         inv_a    <= '0;
         inv_b    <= '0;
         inv_ci   <= 1'b0;
         hold_res <= '0;
         sum_o    <= '0;
         cout_o   <= 1'b0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  hold_res <= {res_co, res_sum};
                  inv_a    <= ~a_i;
                  inv_b    <= ~b_i;
                  inv_ci   <= ~cin_i;
                  phase    <= PH_DUAL;
               end
            end
            PH_DUAL: begin
               done_o <= 1'b1;
               sum_o  <= hold_res[WIDTH-1:0];
               cout_o <= hold_res[WIDTH];
               err_o  <= cmp_bad;
               phase  <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/alt_logic_adder_chk.sv
module alt_logic_adder_chk #(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned ADDER_KIND = altl_pkg::ADD_RIPPLE,
   parameter bit          FAULT_HOOK = 1'b1,
   localparam int unsigned SITE_W    = $clog2(altl_pkg::line_count(WIDTH))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic              cin_i,
   input  logic              flt_en_i,
   input  logic [SITE_W-1:0] flt_site_i,
   input  logic              flt_val_i,
   output logic [WIDTH-1:0]  sum_o,
   output logic              cout_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int unsigned IN_N   = 2 * WIDTH + 1;
   localparam int unsigned OUT_N  = WIDTH + 1;
   localparam int unsigned IN_BASE  = 0;
   localparam int unsigned OUT_BASE = IN_N;

   initial begin
      assert (WIDTH >= 1)
         else $error("alt_logic_adder_chk: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] drv_a;
   logic [WIDTH-1:0] drv_b;
   logic             drv_ci;
   logic [IN_N-1:0]  in_flt;
   logic [WIDTH-1:0] raw_sum;
   logic             raw_co;
   logic [OUT_N-1:0] out_flt;
   logic             busy;

   altl_line_fault #(
      .N(IN_N), .BASE(IN_BASE), .SELW(SITE_W), .HOOK(FAULT_HOOK)
   ) u_in_fault (
      .line_i    ({drv_ci, drv_b, drv_a}),
      .fault_en  (flt_en_i),
      .fault_sel (flt_site_i),
      .fault_val (flt_val_i),
      .line_o    (in_flt)
   );

   altl_adder_core #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_adder (
      .opa (in_flt[WIDTH-1:0]),
      .opb (in_flt[2*WIDTH-1:WIDTH]),
      .ci  (in_flt[2*WIDTH]),
      .sum (raw_sum),
      .co  (raw_co)
   );

   altl_line_fault #(
      .N(OUT_N), .BASE(OUT_BASE), .SELW(SITE_W), .HOOK(FAULT_HOOK)
   ) u_out_fault (
      .line_i    ({raw_co, raw_sum}),
      .fault_en  (flt_en_i),
      .fault_sel (flt_site_i),
      .fault_val (flt_val_i),
      .line_o    (out_flt)
   );

   altl_dual_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .a_i     (a_i),
      .b_i     (b_i),
      .cin_i   (cin_i),
      .res_sum (out_flt[WIDTH-1:0]),
      .res_co  (out_flt[WIDTH]),
      .drv_a   (drv_a),
      .drv_b   (drv_b),
      .drv_ci  (drv_ci),
      .sum_o   (sum_o),
      .cout_o  (cout_o),
      .done_o  (done_o),
      .err_o   (err_o),
      .busy_o  (busy)
   );

endmodule

// File: rtl/alt_logic_adder_chk_sva.sv
module alt_logic_adder_chk_sva #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned SITE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [WIDTH-1:0]  a_i,
   input logic [WIDTH-1:0]  b_i,
   input logic              cin_i,
   input logic              flt_en_i,
   input logic [SITE_W-1:0] flt_site_i,
   input logic [WIDTH-1:0]  sum_o,
   input logic              cout_o,
   input logic              done_o,
   input logic              err_o,
   input logic              busy
);

   localparam logic [SITE_W:0] SITE_LIMIT = (SITE_W+1)'(3 * WIDTH + 2);

   logic in_range;
   assign in_range = ({1'b0, flt_site_i} < SITE_LIMIT);

   // R1
   done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(start, 2) && !$past(busy, 2)));

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   busy_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (done_o && !busy));

   // R2
   clean_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(flt_en_i, 1) && !$past(flt_en_i, 2)) |->
      (({cout_o, sum_o} == ({1'b0, $past(a_i, 2)} + {1'b0, $past(b_i, 2)}
                            + {{WIDTH{1'b0}}, $past(cin_i, 2)})) && !err_o));

   // R4
   fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(flt_en_i, 1) && $past(flt_en_i, 2)
       && ($past(flt_site_i, 1) == $past(flt_site_i, 2)) && $past(in_range, 1)) |-> err_o);

   // R6
   far_site_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(in_range, 1) && !$past(in_range, 2)) |-> !err_o);

   // R8
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({cout_o, sum_o, err_o}));

endmodule

bind alt_logic_adder_chk alt_logic_adder_chk_sva #(.WIDTH(WIDTH), .SITE_W(SITE_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .a_i        (a_i),
   .b_i        (b_i),
   .cin_i      (cin_i),
   .flt_en_i   (flt_en_i),
   .flt_site_i (flt_site_i),
   .sum_o      (sum_o),
   .cout_o     (cout_o),
   .done_o     (done_o),
   .err_o      (err_o),
   .busy       (busy)
);

// File: tb/alt_logic_adder_chk_tb_top.sv
`timescale 1ns/1ps
module alt_logic_adder_chk_tb_top;

   localparam int unsigned W     = 8;
   localparam int unsigned SW    = 5;
   localparam int unsigned NVEC  = 13;

   typedef struct packed {
      logic [W-1:0]  a;
      logic [W-1:0]  b;
      logic          ci;
      logic          fe;
      logic [SW-1:0] fs;
      logic          fv;
   } vec_t;

   // Sites: A bit i = i, B bit i = 8+i, cin = 16, sum bit j = 17+j, cout = 25
   localparam vec_t VECS [NVEC] = '{
      '{8'h00, 8'h00, 1'b0, 1'b0, 5'd0,  1'b0},
      '{8'hFF, 8'h01, 1'b0, 1'b0, 5'd0,  1'b0},
      '{8'hFF, 8'hFF, 1'b1, 1'b0, 5'd0,  1'b0},
      '{8'h5A, 8'hA5, 1'b0, 1'b0, 5'd0,  1'b0},
      '{8'h3C, 8'hC3, 1'b1, 1'b0, 5'd0,  1'b0},
      '{8'h02, 8'h02, 1'b0, 1'b1, 5'd17, 1'b1},
      '{8'h01, 8'h01, 1'b0, 1'b1, 5'd25, 1'b1},
      '{8'h00, 8'h10, 1'b0, 1'b1, 5'd3,  1'b1},
      '{8'h10, 8'h20, 1'b1, 1'b1, 5'd16, 1'b0},
      '{8'h00, 8'hFF, 1'b0, 1'b1, 5'd12, 1'b0},
      '{8'h12, 8'h34, 1'b0, 1'b1, 5'd28, 1'b1},
      '{8'h80, 8'h80, 1'b1, 1'b0, 5'd17, 1'b1},
      '{8'h80, 8'h00, 1'b0, 1'b1, 5'd24, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  a_i = '0;
   logic [W-1:0]  b_i = '0;
   logic          cin_i = 1'b0;
   logic          flt_en_i = 1'b0;
   logic [SW-1:0] flt_site_i = '0;
   logic          flt_val_i = 1'b0;
   logic [W-1:0]  sum_o;
   logic          cout_o;
   logic          done_o;
   logic          err_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   alt_logic_adder_chk #(.WIDTH(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .a_i        (a_i),
      .b_i        (b_i),
      .cin_i      (cin_i),
      .flt_en_i   (flt_en_i),
      .flt_site_i (flt_site_i),
      .flt_val_i  (flt_val_i),
      .sum_o      (sum_o),
      .cout_o     (cout_o),
      .done_o     (done_o),
      .err_o      (err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected {err, cout, sum} from the requirement text
   function automatic logic [W+1:0] model(input vec_t v);
      logic [2*W:0] ins;
      logic [W:0]   r;
      ins = {v.ci, v.b, v.a};
      if (v.fe && v.fs <= 5'(2*W)) ins[v.fs] = v.fv;
      r = {1'b0, ins[W-1:0]} + {1'b0, ins[2*W-1:W]} + {{W{1'b0}}, ins[2*W]};
      if (v.fe && v.fs > 5'(2*W) && v.fs <= 5'(3*W+1)) r[v.fs - 5'(2*W+1)] = v.fv;
      return {(v.fe && v.fs <= 5'(3*W+1)), r};
   endfunction

   task automatic run_vec(input vec_t v, input string req);
      logic [W+1:0] e;
      e = model(v);
      @(negedge clk);
      a_i = v.a; b_i = v.b; cin_i = v.ci;
      flt_en_i = v.fe; flt_site_i = v.fs; flt_val_i = v.fv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " R1 no early done"}, 32'(done_o), 32'd0);
      @(negedge clk);
      chk({req, " R1 done in cycle 2"}, 32'(done_o), 32'd1);
      chk({req, " result"}, 32'({cout_o, sum_o}), 32'(e[W:0]));
      chk({req, " err"}, 32'(err_o), 32'(e[W+1]));
      @(negedge clk);
      chk({req, " R1 single pulse"}, 32'(done_o), 32'd0);
      chk({req, " R8 hold"}, 32'({err_o, cout_o, sum_o}), 32'(e));
      flt_en_i = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 reset outputs", 32'({err_o, done_o, cout_o, sum_o}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         if (VECS[i].fe && VECS[i].fs > 5'(2*W) && VECS[i].fs <= 5'(3*W+1)) tag = "R4 output fault";
         else if (VECS[i].fe && VECS[i].fs <= 5'(2*W)) tag = "R5 input fault";
         else if (VECS[i].fe || VECS[i].fs != 0) tag = "R6 no-effect fault";
         else tag = "R2 clean add";
         run_vec(VECS[i], $sformatf("%s vec%0d", tag, i));
      end

      // R3: every output site flagged for both pinned levels
      for (int s = 2*W+1; s <= 3*W+1; s++) begin
         for (int lv = 0; lv < 2; lv++) begin
            vec_t v;
            v = '{8'h6B, 8'h39, 1'b1, 1'b1, 5'(s), 1'(lv)};
            run_vec(v, $sformatf("R3 site%0d lvl%0d", s, lv));
         end
      end

      // R7 start during second pass ignored
      @(negedge clk);
      a_i = 8'h21; b_i = 8'h43; cin_i = 1'b0; start = 1'b1;
      @(negedge clk);
      a_i = 8'hF0; b_i = 8'hF0; cin_i = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 done from first start", 32'(done_o), 32'd1);
      chk("R7 result of first start", 32'({err_o, cout_o, sum_o}), 32'h064);
      @(negedge clk);
      chk("R7 no second done", 32'(done_o), 32'd0);
      @(negedge clk);
      chk("R7 still no done", 32'(done_o), 32'd0);
      chk("R8 outputs held", 32'({err_o, cout_o, sum_o}), 32'h064);

      // R9 reset clears results
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset after use", 32'({err_o, done_o, cout_o, sum_o}), 32'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule